// File: doc/BRIEF.md
# Banked Split-Space Address Mapper

This block turns a 16-bit logical half-word address into a 19-bit physical half-word address for a machine whose instruction and data address spaces are separate. A logical address with its top bit clear passes through unchanged into physical bank 0. A logical address with its top bit set is redirected into one of sixteen 32K half-word banks. The bank number comes from one of ten 4-bit bank registers, so the block can reach 512K half-words in total.

Instruction fetches take their bank from a fetch-bank field of the status word. Data accesses whose effective address was formed without a base register (base register number 0) take their bank from a data-bank field of the status word. Data accesses formed with a nonzero base register take their bank from one of eight extension registers, indexed by the low three bits of the base register number. The address output is combinational from the current inputs and the registered bank state. A synchronous write port loads any of the ten registers.

Top module: `bankmap_top`

## Requirements
- R1: After reset every bank register holds 0, so every upper-half access, whether fetch or data and whatever the base register, maps to physical bank 0.
- R2: A logical address with bit 15 clear produces phys_addr = {4'b0000, log_addr[14:0]} whatever the bank registers and the access type hold.
- R3: An instruction fetch (acc_is_fetch=1) to an address with bit 15 set produces {fetch bank, log_addr[14:0]}.
- R4: A data access (acc_is_fetch=0) to an address with bit 15 set and base_reg=0 produces {status data bank, log_addr[14:0]}.
- R5: A data access to an address with bit 15 set and base_reg nonzero produces {extension register[base_reg[2:0]], log_addr[14:0]}. base_reg=8 therefore selects extension register 0.
- R6: For an instruction fetch the value of base_reg has no effect on phys_addr.
- R7: Write selector encoding: with wr_en=1 at a clock edge, wr_sel 0..7 loads extension register wr_sel, 8 loads the fetch bank, and 9 loads the status data bank, each from wr_data. wr_sel 10..15 changes no register.
- R8: A write becomes visible to accesses in the cycle after its clock edge. An access in the same cycle as the write still sees the old value.
- R9: With wr_en=0, no register changes, whatever wr_sel and wr_data hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears all bank registers |
| acc_is_fetch | input | 1 | 1 for an instruction fetch, 0 for a data access |
| log_addr | input | 16 | Logical half-word address |
| base_reg | input | 4 | Number of the base register that formed the effective address (0 = none) |
| wr_en | input | 1 | Bank register write enable |
| wr_sel | input | 4 | Register selector: 0..7 extension, 8 fetch bank, 9 data bank |
| wr_data | input | 4 | Bank value to write |
| phys_addr | output | 19 | Physical half-word address |

## Verification
The bench loads all ten registers with distinct values and reads each one back through its own access path. A swapped fetch and data field, or a wrong extension index, therefore shows up as a wrong bank. It probes the half boundary at 0x7FFF and 0x8000 and at 0xFFFF. A design that remapped the lower half, or tested the wrong address bit, would put a nonzero bank on a lower-half address. It checks base register 8 and fetches with a nonzero base. A design that decoded all four base bits, or let the base steer fetches, would pick the wrong register. Writes to the unused selectors 10..15, writes with the enable low, and an access in the same cycle as a write catch a design with loose decoding, a missing enable, or a bypass from write data to the output.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;
    parameter int LOG_W   = 16;
    parameter int BANK_W  = 4;
    parameter int NUM_EXT = 8;
    parameter int SEL_W   = 4;
    parameter int BASE_W  = 4;

    localparam int OFF_W     = LOG_W - 1;
    localparam int PHYS_W    = BANK_W + OFF_W;
    localparam int EXT_IDX_W = $clog2(NUM_EXT);

    typedef struct packed {
        logic [NUM_EXT-1:0][BANK_W-1:0] ext;
        logic [BANK_W-1:0]              ibank;
        logic [BANK_W-1:0]              dbank;
    } bank_state_t;
endpackage

// File: rtl/bankmap_regs.sv
module bankmap_regs
    import bankmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BANK_W-1:0] wr_data,
    output bank_state_t       state_q
);
    bank_state_t state_d;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            for (int i = 0; i < NUM_EXT; i++) begin
                if (wr_sel == SEL_W'(i)) begin
                    state_d.ext[i] = wr_data;
                end
            end
            if (wr_sel == SEL_W'(NUM_EXT)) begin
                state_d.ibank = wr_data;
            end
            if (wr_sel == SEL_W'(NUM_EXT + 1)) begin
                state_d.dbank = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(state_q)); // R9
    AST_FETCH_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_W'(NUM_EXT)) |=> state_q.ibank == $past(wr_data)); // R7
    AST_DATA_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_W'(NUM_EXT + 1)) |=> state_q.dbank == $past(wr_data)); // R7
    AST_UNUSED_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel > SEL_W'(NUM_EXT + 1)) |=> $stable(state_q)); // R7

    for (genvar g = 0; g < NUM_EXT; g++) begin : g_ext_chk
        AST_EXT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_sel == SEL_W'(g)) |=> state_q.ext[g] == $past(wr_data)); // R7
    end
endmodule

// File: rtl/bankmap_select.sv
module bankmap_select
    import bankmap_pkg::*;
(
    input  bank_state_t       state_q,
    input  logic              acc_is_fetch,
    input  logic [BASE_W-1:0] base_reg,
    output logic [BANK_W-1:0] bank
);
    logic [EXT_IDX_W-1:0] ext_idx;

    always_comb begin
        ext_idx = base_reg[EXT_IDX_W-1:0];
        if (acc_is_fetch) begin
            bank = state_q.ibank;
        end else if (base_reg == '0) begin
            bank = state_q.dbank;
        end else begin
            bank = state_q.ext[ext_idx];
        end
    end
endmodule

// File: rtl/bankmap_compose.sv
module bankmap_compose
    import bankmap_pkg::*;
(
    input  logic [LOG_W-1:0]  log_addr,
    input  logic [BANK_W-1:0] bank,
    output logic [PHYS_W-1:0] phys_addr
);
    logic upper;

    always_comb begin
        upper     = log_addr[LOG_W-1];
        phys_addr = {(upper ? bank : BANK_W'(0)), log_addr[OFF_W-1:0]};
    end
endmodule

// File: rtl/bankmap_top.sv
module bankmap_top
    import bankmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_is_fetch,
    input  logic [LOG_W-1:0]  log_addr,
    input  logic [BASE_W-1:0] base_reg,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BANK_W-1:0] wr_data,
    output logic [PHYS_W-1:0] phys_addr
);
    bank_state_t       state_q;
    logic [BANK_W-1:0] bank;

    bankmap_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .state_q (state_q)
    );

    bankmap_select u_sel (
        .state_q      (state_q),
        .acc_is_fetch (acc_is_fetch),
        .base_reg     (base_reg),
        .bank         (bank)
    );

    bankmap_compose u_comp (
        .log_addr  (log_addr),
        .bank      (bank),
        .phys_addr (phys_addr)
    );

    AST_LOWER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !log_addr[LOG_W-1] |-> phys_addr[PHYS_W-1:OFF_W] == '0); // R2
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[OFF_W-1:0] == log_addr[OFF_W-1:0]); // R2
    AST_FETCH_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_is_fetch && log_addr[LOG_W-1]) |-> phys_addr[PHYS_W-1:OFF_W] == state_q.ibank); // R3
    AST_DATA_NOBASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_is_fetch && log_addr[LOG_W-1] && base_reg == '0)
            |-> phys_addr[PHYS_W-1:OFF_W] == state_q.dbank); // R4
endmodule

// File: tb/bankmap_top_test.sv
module bankmap_top_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_is_fetch = 1'b0;
    logic [15:0] log_addr = '0;
    logic [3:0]  base_reg = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_sel = '0;
    logic [3:0]  wr_data = '0;
    logic [18:0] phys_addr;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        logic [18:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    logic [3:0] m_ext [8];
    logic [3:0] m_ib;
    logic [3:0] m_db;

    bankmap_top uut (
        .clk(clk), .rst_n(rst_n), .acc_is_fetch(acc_is_fetch), .log_addr(log_addr),
        .base_reg(base_reg), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .phys_addr(phys_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [18:0] expect_addr(logic f, logic [15:0] a, logic [3:0] b);
        logic [3:0] bk;
        if (!a[15]) return {4'h0, a[14:0]};
        if (f) bk = m_ib;
        else if (b == 4'd0) bk = m_db;
        else bk = m_ext[b[2:0]];
        return {bk, a[14:0]};
    endfunction

    // Driver: one cycle of stimulus; pushes the expected address, then updates the model
    task automatic step(input logic we, input logic [3:0] sel, input logic [3:0] dat,
                        input logic f, input logic [15:0] a, input logic [3:0] b,
                        input string tag);
        item_t it;
        @(posedge clk);
        #1;
        wr_en = we; wr_sel = sel; wr_data = dat;
        acc_is_fetch = f; log_addr = a; base_reg = b;
        it.exp = expect_addr(f, a, b);
        it.tag = tag;
        sb.push_back(it);
        if (we) begin
            if (sel < 4'd8) m_ext[sel[2:0]] = dat;
            else if (sel == 4'd8) m_ib = dat;
            else if (sel == 4'd9) m_db = dat;
        end
    endtask

    // Monitor: compares at the falling edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            n_checks++;
            if (phys_addr !== it.exp) begin
                n_fail++;
                $display("FAIL %s: phys_addr=%05h expected=%05h", it.tag, phys_addr, it.exp);
            end
        end
    end

    task automatic read_all(input string tag);
        for (int i = 1; i < 8; i++) step(0, 0, 0, 0, 16'h8000 | 16'(i * 16'h111), 4'(i), {tag, " R5 ext"});
        step(0, 0, 0, 0, 16'hC123, 4'd8, {tag, " R5 base8"});
        step(0, 0, 0, 0, 16'hFFFF, 4'd0, {tag, " R4 dbank"});
        step(0, 0, 0, 1, 16'h8001, 4'd0, {tag, " R3 fetch"});
    endtask

    initial begin
        for (int i = 0; i < 8; i++) m_ext[i] = 4'h0;
        m_ib = 4'h0;
        m_db = 4'h0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state on every path
        step(0, 0, 0, 1, 16'hFFFF, 4'd0, "R1 fetch");
        step(0, 0, 0, 0, 16'h8000, 4'd0, "R1 data base0");
        step(0, 0, 0, 0, 16'hABCD, 4'd5, "R1 data ext");

        // R7: load every register with a distinct value
        for (int i = 0; i < 8; i++) step(1, 4'(i), 4'(i + 3), 0, 16'h0100, 4'd0, "R7 load ext");
        step(1, 4'd8, 4'hE, 0, 16'h0200, 4'd0, "R7 load ibank");
        step(1, 4'd9, 4'h1, 0, 16'h0300, 4'd0, "R7 load dbank");
        read_all("loaded");

        // R2: lower half untouched by banks
        step(0, 0, 0, 1, 16'h7FFF, 4'd0, "R2 fetch 7FFF");
        step(0, 0, 0, 0, 16'h7FFF, 4'd3, "R2 data 7FFF");
        step(0, 0, 0, 0, 16'h0000, 4'd0, "R2 data 0000");
        step(0, 0, 0, 0, 16'h8000, 4'd2, "R5 boundary 8000");

        // R6: fetch ignores base register
        for (int b = 1; b < 16; b += 5) step(0, 0, 0, 1, 16'h9ABC, 4'(b), "R6 fetch base");

        // R7: unused selectors 10..15 change nothing
        for (int s = 10; s < 16; s++) step(1, 4'(s), 4'hF, 0, 16'h0400, 4'd0, "R7 unused sel");
        read_all("after unused");

        // R9: enable low ignores selector and data
        for (int s = 0; s < 10; s++) step(0, 4'(s), 4'hF, 0, 16'h0500, 4'd0, "R9 idle");
        read_all("after idle");

        // R8: access in the write cycle sees old value, next cycle the new one
        step(1, 4'd8, 4'h7, 1, 16'hF000, 4'd0, "R8 same cycle ibank");
        step(0, 0, 0, 1, 16'hF000, 4'd0, "R8 next cycle ibank");
        step(1, 4'd4, 4'h9, 0, 16'hE000, 4'd4, "R8 same cycle ext4");
        step(0, 0, 0, 0, 16'hE000, 4'd4, "R8 next cycle ext4");
        step(1, 4'd9, 4'hA, 0, 16'hD000, 4'd0, "R8 same cycle dbank");
        step(0, 0, 0, 0, 16'hD000, 4'd0, "R8 next cycle dbank");

        // R1: reset again clears all
        @(posedge clk);
        #1 rst_n = 1'b0;
        for (int i = 0; i < 8; i++) m_ext[i] = 4'h0;
        m_ib = 4'h0;
        m_db = 4'h0;
        @(posedge clk);
        #1 rst_n = 1'b1;
        read_all("R1 re-reset");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule